// File: doc/BRIEF.md
# Scalable 64-bit System Counter

This block keeps a 64-bit system time value that advances on a qualifying input tick. Software controls it through a five-register frame on a simple 32-bit register bus. A control register turns counting on and off and selects scaled mode. A status register reports whether counting is enabled. Two word registers expose the count and let software overwrite it. A scale register holds the increment used in scaled mode.

In scaled mode, each tick adds an unsigned 8.24 fixed-point increment instead of one. The value 0x01000000 stands for 1.0. A 24-bit fractional accumulator keeps the remainder between ticks and carries into the integer count, so software can slow time to a fraction of the tick rate, or speed it up. The full 64-bit value is driven out every cycle for downstream timers.

Bus reads return data one cycle after the request, with a valid strobe. Writes take effect at the clock edge that samples them. Register map: control at 0x00 (bit 0 enable, bit 2 scaled mode), status at 0x04, count low word at 0x08, count high word at 0x0C, scale at 0x10.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset, control reads 0, both count words read 0, status reads 0, and scale reads 0x01000000.
- R2: While control bit 0 is clear, the count holds its value whatever the tick input does.
- R3: With bit 0 set and bit 2 clear, every tick adds exactly one to the count.
- R4: With bits 0 and 2 set, every tick adds the scale value, read as 8.24 fixed point, to the combined count and 24-bit fraction; 0x00100000 gives one count per 16 ticks.
- R5: A write to offset 0x08 or 0x0C replaces that 32-bit half of the count. A count write in the same cycle as a tick takes precedence over the tick.
- R6: Scale values above 1.0 advance the count by more than one per tick; 0x02800000 gives 10 counts over 4 ticks.
- R7: The fraction is cleared by any count write and whenever scaled mode is off. Partial progress made before such an event is never carried into later ticks.
- R8: Status bit 0 reads the current enable bit, all other status bits read 0, and writes to status change nothing.
- R9: A read of the low word captures the high word. A later high-word read returns that captured value, even if the count has moved on.
- R10: The count output always shows the full 64-bit count, and an increment past all ones wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-advance qualifier, one tick per high cycle |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |
| count_o | output | 64 | Current 64-bit count |

## Verification
The hardest case to reach is a fraction that has partly built up at the moment it must be discarded, which is the R7 case.

The bench enables scaled mode at one sixteenth rate and applies eight ticks, so the fraction holds exactly one half. It then overwrites the count. Another eight ticks must leave the count at zero, and a further eight must give one.

Two other cases are set up directly by count writes rather than by waiting for them. For the wrap case, the bench writes all ones and applies one tick. For high-word capture, it loads 0x5_FFFFFFFF, reads the low word, and ticks across the word boundary before reading the high word.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 24;
    localparam int SCALE_W = INT_W + FRAC_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SCALE  = 8'h10;

    localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

    typedef struct packed {
        logic scaled;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic              wr_lo;
        logic              wr_hi;
        logic [DATA_W-1:0] data;
    } cnt_wr_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v    = '0;
        v[0] = c.enable;
        v[2] = c.scaled;
        return v;
    endfunction
endpackage

// File: rtl/ssc_step.sv
module ssc_step
    import ssc_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_INT_W  = INT_W,
    parameter int P_FRAC_W = FRAC_W
) (
    input  logic [P_CNT_W-1:0]          cnt_i,
    input  logic [P_FRAC_W-1:0]         frac_i,
    input  logic [P_INT_W+P_FRAC_W-1:0] scale_i,
    input  logic                        scaled_i,
    output logic [P_CNT_W-1:0]          cnt_o,
    output logic [P_FRAC_W-1:0]         frac_o
);
    localparam int SUM_W = P_INT_W + P_FRAC_W + 1;
    logic [SUM_W-1:0]   sum;
    logic [P_INT_W:0]   whole;

    always_comb begin
        sum   = SUM_W'(frac_i) + SUM_W'(scale_i);
        whole = sum[SUM_W-1:P_FRAC_W];
        if (scaled_i) begin
            cnt_o  = cnt_i + P_CNT_W'(whole);
            frac_o = sum[P_FRAC_W-1:0];
        end else begin
            cnt_o  = cnt_i + P_CNT_W'(1);
            frac_o = '0;
        end
    end
endmodule

// File: rtl/ssc_core.sv
module ssc_core
    import ssc_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_INT_W  = INT_W,
    parameter int P_FRAC_W = FRAC_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick_i,
    input  ctrl_t                       ctrl_i,
    input  logic [P_INT_W+P_FRAC_W-1:0] scale_i,
    input  cnt_wr_t                     wr_i,
    output logic [P_CNT_W-1:0]          cnt_o
);
    localparam int HALF = P_CNT_W / 2;

    logic [P_CNT_W-1:0]  cnt_q, cnt_nx;
    logic [P_FRAC_W-1:0] frac_q, frac_nx;

    ssc_step #(.P_CNT_W(P_CNT_W), .P_INT_W(P_INT_W), .P_FRAC_W(P_FRAC_W)) u_step (
        .cnt_i   (cnt_q),
        .frac_i  (frac_q),
        .scale_i (scale_i),
        .scaled_i(ctrl_i.scaled),
        .cnt_o   (cnt_nx),
        .frac_o  (frac_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            frac_q <= '0;
        end else if (wr_i.wr_lo || wr_i.wr_hi) begin
            if (wr_i.wr_lo) cnt_q[HALF-1:0]       <= wr_i.data[HALF-1:0];
            if (wr_i.wr_hi) cnt_q[P_CNT_W-1:HALF] <= wr_i.data[HALF-1:0];
            frac_q <= '0;
        end else if (ctrl_i.enable && tick_i) begin
            cnt_q  <= cnt_nx;
            frac_q <= frac_nx;
        end else if (!ctrl_i.scaled) begin
            frac_q <= '0;
        end
    end

    assign cnt_o = cnt_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.enable && !wr_i.wr_lo && !wr_i.wr_hi) |=> $stable(cnt_q));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.enable && !ctrl_i.scaled && tick_i && !wr_i.wr_lo && !wr_i.wr_hi)
        |=> (cnt_q == $past(cnt_q) + P_CNT_W'(1)));

    assert_step_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.enable && ctrl_i.scaled && tick_i && !wr_i.wr_lo && !wr_i.wr_hi)
        |=> ((cnt_q - $past(cnt_q)) <= P_CNT_W'(1 << P_INT_W)));

    assert_frac_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_i.wr_lo || wr_i.wr_hi) |=> (frac_q == '0));
endmodule

// File: rtl/ssc_regfile.sv
module ssc_regfile
    import ssc_pkg::*;
#(
    parameter int P_CNT_W   = CNT_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_SCALE_W = SCALE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [P_ADDR_W-1:0]  req_addr_i,
    input  logic [P_DATA_W-1:0]  req_wdata_i,
    input  logic [P_CNT_W-1:0]   cnt_i,
    output logic                 rsp_valid_o,
    output logic [P_DATA_W-1:0]  rsp_rdata_o,
    output ctrl_t                ctrl_o,
    output logic [P_SCALE_W-1:0] scale_o,
    output cnt_wr_t              wr_o
);
    localparam int HALF = P_CNT_W / 2;

    logic                wr_en, rd_en;
    ctrl_t               ctrl_q;
    logic [P_SCALE_W-1:0] scale_q;
    logic [HALF-1:0]     hi_cap_q;
    logic [P_DATA_W-1:0] rd_mux;

    assign wr_en = req_valid_i &&  req_write_i;
    assign rd_en = req_valid_i && !req_write_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            scale_q <= SCALE_ONE;
        end else if (wr_en) begin
            if (req_addr_i == OFS_CTRL) begin
                ctrl_q.enable <= req_wdata_i[0];
                ctrl_q.scaled <= req_wdata_i[2];
            end
            if (req_addr_i == OFS_SCALE) scale_q <= req_wdata_i[P_SCALE_W-1:0];
        end
    end

    always_comb begin
        wr_o.wr_lo = wr_en && (req_addr_i == OFS_CNT_LO);
        wr_o.wr_hi = wr_en && (req_addr_i == OFS_CNT_HI);
        wr_o.data  = req_wdata_i;
    end

    always_comb begin
        case (req_addr_i)
            OFS_CTRL:   rd_mux = pack_ctrl(ctrl_q);
            OFS_STATUS: rd_mux = {{(P_DATA_W-1){1'b0}}, ctrl_q.enable};
            OFS_CNT_LO: rd_mux = cnt_i[HALF-1:0];
            OFS_CNT_HI: rd_mux = hi_cap_q;
            OFS_SCALE:  rd_mux = P_DATA_W'(scale_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
            hi_cap_q    <= '0;
        end else begin
            rsp_valid_o <= rd_en;
            if (rd_en) rsp_rdata_o <= rd_mux;
            if (rd_en && req_addr_i == OFS_CNT_LO) hi_cap_q <= cnt_i[P_CNT_W-1:HALF];
        end
    end

    assign ctrl_o  = ctrl_q;
    assign scale_o = scale_q;

    assert_status_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && req_addr_i == OFS_STATUS)
        |=> (rsp_rdata_o == {{(P_DATA_W-1){1'b0}}, $past(ctrl_q.enable)}));

    assert_status_wr_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req_addr_i == OFS_STATUS) |=> $stable(ctrl_q));

    assert_rsp_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rsp_valid_o);
endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [CNT_W-1:0]  count_o
);
    ctrl_t              ctrl;
    logic [SCALE_W-1:0] scale;
    cnt_wr_t            cnt_wr;

    ssc_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .req_addr_i (req_addr_i),
        .req_wdata_i(req_wdata_i),
        .cnt_i      (count_o),
        .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o),
        .ctrl_o     (ctrl),
        .scale_o    (scale),
        .wr_o       (cnt_wr)
    );

    ssc_core u_core (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .ctrl_i (ctrl),
        .scale_i(scale),
        .wr_i   (cnt_wr),
        .cnt_o  (count_o)
    );

    assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !ctrl.scaled && tick_i && !cnt_wr.wr_lo && !cnt_wr.wr_hi
         && count_o == '1) |=> (count_o == '0));
endmodule

// File: tb/scaled_sys_counter_bench.sv
module scaled_sys_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        rsp_valid_o;
    logic [31:0] rsp_rdata_o;
    logic [63:0] count_o;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    scaled_sys_counter u_scaled_sys_counter (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
        .count_o(count_o)
    );

    always @(negedge clk) begin
        if (!rst && rsp_valid_o) begin
            item_t it;
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected response got %h exp none", rsp_rdata_o);
            end else begin
                it = exp_q.pop_front();
                if (rsp_rdata_o !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s got %h exp %h", it.tag, rsp_rdata_o, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 0; req_write_i = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk);
        req_valid_i = 1; req_write_i = 0; req_addr_i = a;
        @(negedge clk);
        req_valid_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1;
        end
        @(negedge clk);
        tick_i = 0;
    endtask

    task automatic chk64(input logic [63:0] e, input string tag);
        n_cmp++;
        if (count_o !== e) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, count_o, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        bus_rd(8'h00, 32'h0, "R1 ctrl");
        bus_rd(8'h04, 32'h0, "R1 status");
        bus_rd(8'h08, 32'h0, "R1 lo");
        bus_rd(8'h0C, 32'h0, "R1 hi");
        bus_rd(8'h10, 32'h0100_0000, "R1 scale");
        // R2 disabled holds
        ticks(100);
        bus_rd(8'h08, 32'h0, "R2 hold");
        // R3 unit rate
        bus_wr(8'h00, 32'h1);
        ticks(100);
        bus_rd(8'h08, 32'd100, "R3 lo");
        bus_rd(8'h0C, 32'h0, "R3 hi");
        // R8 status
        bus_rd(8'h04, 32'h1, "R8 status on");
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h00, 32'h1, "R8 ctrl after status write");
        bus_rd(8'h04, 32'h1, "R8 status after write");
        // R4 sixteenth rate
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h10, 32'h0010_0000);
        bus_wr(8'h00, 32'h5);
        bus_rd(8'h00, 32'h5, "R4 ctrl readback");
        ticks(160);
        bus_rd(8'h08, 32'd110, "R4 sixteenth");
        // R5 count write
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h0C, 32'h0);
        bus_rd(8'h08, 32'h0, "R5 cleared lo");
        bus_rd(8'h0C, 32'h0, "R5 cleared hi");
        // R5 write beats a tick in the same cycle
        @(negedge clk);
        tick_i = 1; req_valid_i = 1; req_write_i = 1; req_addr_i = 8'h08; req_wdata_i = 32'd7;
        @(negedge clk);
        tick_i = 0; req_valid_i = 0; req_write_i = 0;
        chk64(64'd7, "R5 write over tick");
        // R7 fraction cleared by count write
        bus_wr(8'h08, 32'h0);
        ticks(8);
        bus_wr(8'h08, 32'h0);
        ticks(8);
        bus_rd(8'h08, 32'h0, "R7 after write");
        ticks(8);
        bus_rd(8'h08, 32'h1, "R7 fresh carry");
        // R7 fraction cleared by leaving scaled mode
        bus_wr(8'h08, 32'h0);
        ticks(8);
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h00, 32'h5);
        ticks(8);
        bus_rd(8'h08, 32'h0, "R7 after mode off");
        // R6 above unity
        bus_wr(8'h10, 32'h0280_0000);
        bus_wr(8'h08, 32'h0);
        ticks(4);
        bus_rd(8'h08, 32'd10, "R6 two and a half");
        // R9 high capture
        bus_wr(8'h00, 32'h1);
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'h5);
        bus_rd(8'h08, 32'hFFFF_FFFF, "R9 lo");
        ticks(3);
        bus_rd(8'h0C, 32'h5, "R9 captured hi");
        bus_rd(8'h08, 32'h2, "R9 new lo");
        bus_rd(8'h0C, 32'h6, "R9 new hi");
        // R10 output and wrap
        chk64(64'h6_0000_0002, "R10 output");
        bus_wr(8'h08, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        chk64(64'hFFFF_FFFF_FFFF_FFFF, "R10 all ones");
        ticks(1);
        chk64(64'h0, "R10 wrap");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL pending responses got %0d exp 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule